// File: doc/BRIEF.md
# MDIO Management Frame Generator

This block sends one MII management frame to an external PHY each time software writes the 32-bit frame register. It first sends a preamble of consecutive ones. It then sends the frame register most significant bit first. The serial clock is a divided copy of the system clock. A read opcode makes the block release the data line partway through the frame and collect the sixteen bits the PHY returns into the data field of the frame register. A write or any other opcode drives the line for the whole frame. A single-cycle pulse and a sticky flag report that the frame has finished.

A launch needs two things: a frame register write and a non-zero divider. When the divider is zero, a frame register write is held as pending and nothing appears on the line. The first later divider write with a non-zero value sends the held frame. Software can therefore program the two registers in either order. A frame register write that arrives while a frame is in flight is dropped.

Field layout of the frame register, counted from the first bit sent, which is bit 31:

| Bits | Field |
|---|---|
| [31:30] | start pattern |
| [29:28] | opcode |
| [27:23] | PHY address |
| [22:18] | register number |
| [17:16] | turnaround |
| [15:0] | data |

The frame register has no reset value.

Top module: `mdio_frame_engine`

## Requirements
- R1: When `frm_wr` is asserted while idle and the divider is non-zero, a frame is sent. On the first 32 rising edges of `mdc`, `mdio_o` is 1. On the next 32 rising edges it carries the frame register from bit 31 down to bit 0. Exactly 64 rising edges of `mdc` occur per frame.
- R2: With divider value D, `mdc` stays high for exactly D system clocks and stays low for exactly D system clocks between bits. While idle, `mdc` is low.
- R3: A frame register write made while the divider is zero produces no `mdc` activity. A later divider write with a non-zero value launches a frame carrying the most recent frame register data.
- R4: A divider write of zero while a frame is pending does not launch it, and the frame stays pending.
- R5: When the opcode bits [29:28] equal 2'b10 (read), `mdio_oe` is low from frame bit 15 (rising edge 48) to the end of the frame. The 16 bits sampled from `mdio_i` on the last 16 rising edges are stored into [15:0], first received bit at bit 15. After completion, `frm_rdata` shows them with bits [31:16] unchanged.
- R6: For any opcode other than 2'b10, `mdio_oe` is high on every rising edge of the frame.
- R7: At the end of the final bit, `done_pulse` is high for exactly one cycle and `done_flag` becomes 1. The flag stays 1 until `done_clr` is asserted, which clears it.
- R8: A frame register write while a frame is in progress is ignored. The register contents are unchanged and no extra frame follows.
- R9: After reset: `mdc` = 0, `mdio_oe` = 0, `mdio_o` = 1, `done_pulse` = 0, `done_flag` = 0, and the divider is zero.
- R10: While idle, `frm_rdata` returns the most recently accepted frame register write.
- R11: The divider value is captured at launch. A divider write during a frame does not change that frame's `mdc` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_wr | input | 1 | Write strobe for the frame register |
| frm_wdata | input | 32 | Frame register write data |
| frm_rdata | output | 32 | Frame register read data |
| div_wr | input | 1 | Write strobe for the divider |
| div_wdata | input | DIV_W | Divider value; 0 halts launches |
| done_clr | input | 1 | Write-one clear of the done flag |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check the following on every cycle:
- the clock divider count stays inside the latched divider;
- the bit index never moves backwards during a frame;
- the line is released only for a read opcode and is always driven for other opcodes;
- the completion pulse lasts a single cycle and raises the flag;
- a zero divider holds the block idle;
- a write during a frame leaves the header fields untouched.

Only the bench scenarios can show the end-to-end results. These are:
- the exact 64-bit serial pattern;
- the measured half periods of `mdc`;
- the data returned from a modeled PHY landing in the register;
- the write-in-either-order launch sequence;
- the absence of a second frame after an ignored write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Register layout constants; bit 31 is the first bit on the line.
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int OP_HI   = 29;            // opcode occupies [OP_HI:OP_HI-1]
  localparam logic [1:0] OP_RD = 2'b10;   // read opcode
  localparam int TA2_POS = 15;            // second turnaround bit, counted from the first frame bit
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_act,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             half_end;

  assign half_end  = (cnt == div_act - 1'b1);
  assign rise_tick = run & ~mdc & half_end;
  assign fall_tick = run &  mdc & half_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div_act));

  // R2
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc);
endmodule

// File: rtl/mdio_launch_ctl.sv
module mdio_launch_ctl #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_wr,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             busy,
  output logic             launch,
  output logic             load_frame,
  output logic [DIV_W-1:0] div_act
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             pend_q;
  logic             want;

  assign div_next   = div_wr ? div_wdata : div_q;
  assign want       = ~busy & (frm_wr | pend_q);
  assign launch     = want & (div_next != '0);
  assign load_frame = frm_wr & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      div_act <= '0;
      pend_q  <= 1'b0;
    end else begin
      div_q <= div_next;
      if (launch) begin
        div_act <= div_next;
        pend_q  <= 1'b0;
      end else if (want) begin
        pend_q  <= 1'b1;
      end
    end
  end

  // R3
  zero_div_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && div_q == '0 && !div_wr) |=> !busy);

  // R11
  div_act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_act));
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               load_frame,
  input  logic [FRAME_W-1:0] wdata,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done_evt,
  output logic [FRAME_W-1:0] frame_q,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] REL_I  = IDX_W'(PRE_LEN + TA2_POS);
  localparam logic [IDX_W-1:0] CAP_I  = IDX_W'(PRE_LEN + TA2_POS + 1);

  logic [IDX_W-1:0]   idx;
  logic               rd_op;
  logic [FRAME_W-1:0] shifted;

  assign rd_op    = (frame_q[OP_HI -: 2] == OP_RD);
  assign done_evt = busy & fall_tick & (idx == LAST_I);
  assign shifted  = frame_q >> (LAST_I - idx);

  always_comb begin
    if (!busy || idx < PRE_I) mdio_o = 1'b1;
    else                      mdio_o = shifted[0];
  end
  assign mdio_oe = busy & ~(rd_op & (idx >= REL_I));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && fall_tick) begin
      if (idx == LAST_I) busy <= 1'b0;
      else               idx  <= idx + 1'b1;
    end
  end

  // Frame register: deliberately left without a reset value.
  always_ff @(posedge clk) begin
    if (load_frame)
      frame_q <= wdata;
    else if (busy && rise_tick && rd_op && idx >= CAP_I)
      frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
  end

  // R1
  idx_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx >= $past(idx)));

  // R5
  release_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> rd_op);

  // R6
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_op) |-> mdio_oe);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_wr,
  input  logic [FRAME_W-1:0] frm_wdata,
  output logic [FRAME_W-1:0] frm_rdata,
  input  logic               div_wr,
  input  logic [DIV_W-1:0]   div_wdata,
  input  logic               done_clr,
  output logic               done_pulse,
  output logic               done_flag,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic             busy;
  logic             launch;
  logic             load_frame;
  logic [DIV_W-1:0] div_act;
  logic             rise_tick;
  logic             fall_tick;
  logic             done_evt;

  mdio_launch_ctl #(.DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .frm_wr(frm_wr), .div_wr(div_wr),
    .div_wdata(div_wdata), .busy(busy), .launch(launch),
    .load_frame(load_frame), .div_act(div_act)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_act(div_act),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_shift #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n), .launch(launch), .load_frame(load_frame),
    .wdata(frm_wdata), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy(busy), .done_evt(done_evt), .frame_q(frm_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      done_pulse <= done_evt;
      if (done_evt)      done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R7
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done_flag);

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frm_wr) |=> (frm_rdata[FRAME_W-1:DATA_W] == $past(frm_rdata[FRAME_W-1:DATA_W])));
endmodule

// File: tb/mdio_frame_engine_tb.sv
module mdio_frame_engine_tb;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             frm_wr = 1'b0;
  logic [31:0]      frm_wdata = '0;
  logic [31:0]      frm_rdata;
  logic             div_wr = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic             done_clr = 1'b0;
  logic             done_pulse, done_flag, mdc, mdio_o, mdio_oe;
  logic             mdio_i = 1'b1;

  mdio_frame_engine #(.DIV_W(DIV_W), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_wr(frm_wr), .frm_wdata(frm_wdata),
    .frm_rdata(frm_rdata), .div_wr(div_wr), .div_wdata(div_wdata),
    .done_clr(done_clr), .done_pulse(done_pulse), .done_flag(done_flag),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Line monitor and PHY model
  int rc = 0;
  bit obs_o [64];
  bit obs_oe [64];
  bit phy_rd = 0;
  logic [15:0] phy_val = '0;

  always @(posedge mdc) begin
    #1;
    if (rc < 64) begin
      obs_o[rc]  = mdio_o;
      obs_oe[rc] = mdio_oe;
    end
    rc++;
  end

  always @(negedge mdc) begin
    #1;
    if (!phy_rd) mdio_i = 1'b1;
    else if (rc == 47) mdio_i = 1'b0;
    else if (rc >= 48 && rc < 64) mdio_i = phy_val[63 - rc];
    else mdio_i = 1'b1;
  end

  // Half-period and pulse monitors
  logic prev_mdc = 1'b0;
  int hlen = 0;
  bit seen_fall = 0;
  int half_err = 0;
  int cur_div = 1;
  int pulse_cnt = 0;
  int pulse_err = 0;
  logic prev_dp = 1'b0;

  always @(negedge clk) begin
    if (mdc !== prev_mdc) begin
      if (prev_mdc) begin
        if (hlen != cur_div) half_err++;
        seen_fall = 1;
      end else if (seen_fall && hlen != cur_div) half_err++;
      hlen = 1;
    end else hlen++;
    prev_mdc = mdc;
    if (done_pulse) begin
      pulse_cnt++;
      if (prev_dp) pulse_err++;
    end
    prev_dp = done_pulse;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_frame(input logic [31:0] d);
    @(posedge clk); #1; frm_wr = 1'b1; frm_wdata = d;
    @(posedge clk); #1; frm_wr = 1'b0;
  endtask

  task automatic wr_div(input int d);
    @(posedge clk); #1; div_wr = 1'b1; div_wdata = DIV_W'(d);
    @(posedge clk); #1; div_wr = 1'b0;
  endtask

  task automatic clr_done();
    @(posedge clk); #1; done_clr = 1'b1;
    @(posedge clk); #1; done_clr = 1'b0;
  endtask

  task automatic arm(input logic [31:0] w, input int dv, input logic [15:0] rv);
    rc = 0; seen_fall = 0; half_err = 0; cur_div = dv;
    pulse_cnt = 0; pulse_err = 0;
    phy_rd = (w[29:28] == 2'b10);
    phy_val = rv;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done_pulse) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [31:0] w, input logic [15:0] rv);
    return (w[29:28] == 2'b10) ? {w[31:16], rv} : w;
  endfunction

  task automatic verify(input logic [31:0] w, input logic [15:0] rv);
    bit ok;
    int bit_mis;
    int oe_mis;
    bit rd;
    rd = (w[29:28] == 2'b10);
    wait_done(ok);
    chk(ok, "R1 completion seen", {31'd0, ok}, 32'd1);
    repeat (3) @(negedge clk);
    bit_mis = 0; oe_mis = 0;
    for (int i = 0; i < 64; i++) begin
      bit eo;
      bit eoe;
      eo  = (i < 32) ? 1'b1 : w[63 - i];
      eoe = rd ? (i < 47) : 1'b1;
      if (eoe && obs_o[i] != eo) bit_mis++;
      if (obs_oe[i] != eoe) oe_mis++;
    end
    chk(rc == 64, "R1 rising edge count", rc, 64);
    chk(bit_mis == 0, "R1 serial bits", bit_mis, 0);
    if (rd) chk(oe_mis == 0, "R5 release window", oe_mis, 0);
    else    chk(oe_mis == 0, "R6 drive window", oe_mis, 0);
    chk(half_err == 0, "R2 half period", half_err, 0);
    chk(pulse_cnt == 1 && pulse_err == 0, "R7 single pulse", pulse_cnt, 1);
    chk(done_flag == 1'b1, "R7 flag set", {31'd0, done_flag}, 1);
    if (rd) chk(frm_rdata == exp_rdata(w, rv), "R5 captured data", frm_rdata, exp_rdata(w, rv));
    else    chk(frm_rdata == w, "R10 readback", frm_rdata, w);
    repeat (5) @(negedge clk);
    chk(done_flag == 1'b1, "R7 flag sticky", {31'd0, done_flag}, 1);
    clr_done();
    @(negedge clk);
    chk(done_flag == 1'b0, "R7 flag cleared", {31'd0, done_flag}, 0);
  endtask

  task automatic run_frame(input logic [31:0] w, input int dv, input logic [15:0] rv);
    wr_div(dv);
    arm(w, dv, rv);
    wr_frame(w);
    verify(w, rv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb, w;
    bit ok;
    void'($urandom(32'd5150));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R9 line idle",
        {29'd0, mdc, mdio_oe, mdio_o}, 32'd1);
    chk(done_flag == 1'b0 && done_pulse == 1'b0, "R9 done clear",
        {30'd0, done_flag, done_pulse}, 0);

    // R3 / R4: frame first, divider later
    wa = 32'h5A1F_1234;
    wb = 32'h5B2E_C0DE;
    arm(wa, 3, 16'h0);
    wr_frame(wa);
    repeat (50) @(negedge clk);
    chk(rc == 0 && !done_flag, "R3 held with zero divider", rc, 0);
    wr_frame(wb);
    @(negedge clk);
    chk(frm_rdata == wb, "R10 pending overwrite", frm_rdata, wb);
    wr_div(0);
    repeat (50) @(negedge clk);
    chk(rc == 0 && !done_flag, "R4 zero divider keeps pending", rc, 0);
    arm(wb, 3, 16'h0);
    wr_div(3);
    verify(wb, 16'h0);

    // Boundary divider of 1, read and write
    run_frame(32'h6A5C_0000, 1, 16'hA55A);
    run_frame(32'h5ACD_FFFF, 1, 16'h0);

    // R8: write during frame is ignored
    wa = 32'h5123_4567;
    run_frame_start: begin
      wr_div(3);
      arm(wa, 3, 16'h0);
      wr_frame(wa);
      repeat (40) @(posedge clk);
      wr_frame(32'h6FFF_0000);
      verify(wa, 16'h0);
      rc = 0;
      repeat (300) @(negedge clk);
      chk(rc == 0 && !done_flag, "R8 no extra frame", rc, 0);
      chk(frm_rdata == wa, "R8 register unchanged", frm_rdata, wa);
    end

    // R11: divider change mid-frame
    w = 32'h6B9D_0000;
    wr_div(2);
    arm(w, 2, 16'h3C96);
    wr_frame(w);
    repeat (30) @(posedge clk);
    wr_div(5);
    verify(w, 16'h3C96);
    chk(half_err == 0, "R11 timing frozen", half_err, 0);

    // Constrained random frames
    for (int n = 0; n < 10; n++) begin
      int dv;
      logic [1:0] op;
      logic [15:0] rv;
      dv = 1 + ($urandom % 4);
      op = 2'($urandom % 4);
      rv = 16'($urandom);
      w  = {2'b01, op, 28'($urandom)};
      run_frame(w, dv, rv);
    end

    wait_done(ok);
    chk(!ok, "R8 quiet after last frame", {31'd0, ok}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule